// File: doc/BRIEF.md
# Group-1 Operate Micro-Operation Unit

This block carries out the register-only "operate" instructions of a 12-bit accumulator machine. One instruction word selects any mix of eight micro-operations: clearing or complementing the accumulator, clearing or complementing the link bit, incrementing, rotating right or left, and swapping bytes. The block applies all the selected micro-operations to the 12-bit accumulator and the 1-bit link in one combinational pass, in a fixed order. The result is stored in the state registers on the next clock edge.

A sequencer presents a word with a one-cycle valid strobe. The block acts only on words of its own instruction group and ignores every other word. A separate load port writes the accumulator and the link directly, for example to set up state before a program runs. A word that asks for both rotate directions at once is treated as undefined: the state is kept and an error flag is raised.

Top module: `opr1_unit`

## Requirements
- R1: While reset is asserted and after it is released, `acc` reads 0, `link` reads 0 and `rot_err` reads 0 until the first update.
- R2: When `load_en` is high at a clock edge, `acc` and `link` take `load_acc` and `load_link` at that edge. The load wins over a word presented in the same cycle.
- R3: A word is accepted only when bits 11:9 equal 7 and bit 8 equals 0. Any other word, and any cycle without `instr_valid`, leaves `acc` and `link` unchanged.
- R4: Bit 7 clears the accumulator and bit 6 clears the link. Both clears act before every other micro-operation.
- R5: Bit 5 inverts all 12 accumulator bits, so the result stays within 0..07777. Bit 4 inverts the link. Both act after the clears.
- R6: Bit 0 adds one to the accumulator modulo 4096, after the complements. When the sum wraps to 0 the link is inverted, not set.
- R7: Bit 3 rotates the 13-bit value {link, acc} right by one place, and bit 2 rotates it left by one place. The rotation acts on the value left by the increment.
- R8: Bit 1 set together with exactly one rotate bit makes the rotation two places instead of one.
- R9: Bit 1 with no rotate bit exchanges accumulator bits 11:6 and 5:0 and leaves the link as it is.
- R10: An accepted word with both bits 3 and 2 set leaves `acc` and `link` unchanged and drives `rot_err` high for the following cycle.
- R11: `rot_err` is low after every cycle that did not accept a word with both rotate bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Strobe qualifying `instr` for one cycle |
| instr | input | 12 | Instruction word |
| load_en | input | 1 | Direct write of accumulator and link |
| load_acc | input | 12 | Accumulator value for a direct write |
| load_link | input | 1 | Link value for a direct write |
| acc | output | 12 | Registered accumulator |
| link | output | 1 | Registered link |
| rot_err | output | 1 | Registered flag for a word with conflicting rotate bits |

## Verification
The properties assume that `load_en` and `instr_valid` are driven to known levels every cycle after reset. They also assume that the internal synchronized reset has been released before any update is checked. The bench changes inputs only on the falling edge, holds the strobes low during reset, and waits out the synchronizer stages before the first stimulus. Every word is presented once, after a load of a known accumulator and link. This keeps each result tied to a single accepted word.

// File: rtl/opr1_pkg.sv
package opr1_pkg;

  // Decoded micro-operation controls of one operate word
  typedef struct packed {
    logic clr_a;   // clear accumulator
    logic clr_l;   // clear link
    logic inv_a;   // invert accumulator
    logic inv_l;   // invert link
    logic rot_r;   // rotate right
    logic rot_l;   // rotate left
    logic dbl;     // byte swap / double rotate
    logic inc;     // increment
  } opr1_ctl_t;

  localparam int unsigned MAJOR_W = 3;

endpackage

// File: rtl/opr1_decode.sv
module opr1_decode
  import opr1_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic [DW-1:0] word,
  output opr1_ctl_t     ctl,
  output logic          is_grp1,
  output logic          rot_conflict
);
  localparam int unsigned GRP_BIT = DW - MAJOR_W - 1;
  localparam logic [MAJOR_W-1:0] OPR_MAJOR = '1;

  always_comb begin
    is_grp1      = (word[DW-1 -: MAJOR_W] == OPR_MAJOR) && !word[GRP_BIT];
    ctl.clr_a    = word[7];
    ctl.clr_l    = word[6];
    ctl.inv_a    = word[5];
    ctl.inv_l    = word[4];
    ctl.rot_r    = word[3];
    ctl.rot_l    = word[2];
    ctl.dbl      = word[1];
    ctl.inc      = word[0];
    rot_conflict = word[3] && word[2];
  end
endmodule

// File: rtl/opr1_arith.sv
module opr1_arith
  import opr1_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  opr1_ctl_t     ctl,
  input  logic [DW-1:0] a_in,
  input  logic          l_in,
  output logic [DW-1:0] a_out,
  output logic          l_out
);
  logic [DW-1:0] a_clr, a_cmp;
  logic          l_clr, l_cmp;
  logic [DW:0]   sum;

  always_comb begin
    a_clr = ctl.clr_a ? '0 : a_in;
    l_clr = ctl.clr_l ? 1'b0 : l_in;
    a_cmp = ctl.inv_a ? ~a_clr : a_clr;
    l_cmp = ctl.inv_l ? ~l_clr : l_clr;
    sum   = {1'b0, a_cmp} + {{DW{1'b0}}, ctl.inc};
    a_out = sum[DW-1:0];
    l_out = l_cmp ^ sum[DW];
  end
endmodule

// File: rtl/opr1_rotate.sv
module opr1_rotate
  import opr1_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  opr1_ctl_t     ctl,
  input  logic [DW-1:0] a_in,
  input  logic          l_in,
  output logic [DW-1:0] a_out,
  output logic          l_out
);
  localparam int unsigned HALF = DW / 2;

  logic [DW:0] v, r1, r2, q1, q2, res;
  logic [DW-1:0] swp;

  assign v = {l_in, a_in};

  genvar gi;
  generate
    for (gi = 0; gi < HALF; gi++) begin : g_swap
      assign swp[gi]        = a_in[gi + HALF];
      assign swp[gi + HALF] = a_in[gi];
    end
  endgenerate

  always_comb begin
    r1 = {v[0], v[DW:1]};
    r2 = {v[1:0], v[DW:2]};
    q1 = {v[DW-1:0], v[DW]};
    q2 = {v[DW-2:0], v[DW:DW-1]};
    if (ctl.rot_r && !ctl.rot_l)      res = ctl.dbl ? r2 : r1;
    else if (ctl.rot_l && !ctl.rot_r) res = ctl.dbl ? q2 : q1;
    else if (!ctl.rot_r && ctl.dbl)   res = {l_in, swp};
    else                              res = v;
    a_out = res[DW-1:0];
    l_out = res[DW];
  end
endmodule

// File: rtl/opr1_unit.sv
module opr1_unit
  import opr1_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [DW-1:0] instr,
  input  logic          load_en,
  input  logic [DW-1:0] load_acc,
  input  logic          load_link,
  output logic [DW-1:0] acc,
  output logic          link,
  output logic          rot_err
);
  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[SYNC_STAGES-1];

  opr1_ctl_t     ctl;
  logic          is_grp1, rot_conflict;
  logic [DW-1:0] mid_a, fin_a;
  logic          mid_l, fin_l;

  opr1_decode #(.DW(DW)) u_dec (
    .word(instr), .ctl(ctl), .is_grp1(is_grp1), .rot_conflict(rot_conflict)
  );
  opr1_arith #(.DW(DW)) u_arith (
    .ctl(ctl), .a_in(acc), .l_in(link), .a_out(mid_a), .l_out(mid_l)
  );
  opr1_rotate #(.DW(DW)) u_rot (
    .ctl(ctl), .a_in(mid_a), .l_in(mid_l), .a_out(fin_a), .l_out(fin_l)
  );

  logic [DW-1:0] acc_q, acc_d;
  logic          link_q, link_d, err_q, err_d, state_en;

  always_comb begin
    acc_d    = acc_q;
    link_d   = link_q;
    err_d    = 1'b0;
    state_en = 1'b0;
    if (load_en) begin
      acc_d    = load_acc;
      link_d   = load_link;
      state_en = 1'b1;
    end else if (instr_valid && is_grp1) begin
      if (rot_conflict) begin
        err_d = 1'b1;
      end else begin
        acc_d    = fin_a;
        link_d   = fin_l;
        state_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      acc_q  <= '0;
      link_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_d;
      if (state_en) begin
        acc_q  <= acc_d;
        link_q <= link_d;
      end
    end
  end

  assign acc     = acc_q;
  assign link    = link_q;
  assign rot_err = err_q;

  // R2: direct write lands on the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n_sync)
    load_en |=> (acc == $past(load_acc)) && (link == $past(load_link)));

  // R3: idle cycles and foreign words keep state
  a_r3_ignore: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!load_en && !(instr_valid && is_grp1)) |=> $stable(acc) && $stable(link));

  // R10: conflicting rotate bits hold state and flag
  a_r10_conflict: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!load_en && instr_valid && is_grp1 && ctl.rot_r && ctl.rot_l)
      |=> rot_err && $stable(acc) && $stable(link));

  // R11: flag only after a conflicting accepted word
  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_en || !instr_valid || !is_grp1 || !rot_conflict) |=> !rot_err);

  // R7/R8/R9: pure rotate or swap preserves the number of set bits
  a_r7_rot_bits: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!load_en && instr_valid && is_grp1 && !ctl.clr_a && !ctl.clr_l &&
     !ctl.inv_a && !ctl.inv_l && !ctl.inc && !(ctl.rot_r && ctl.rot_l))
      |=> $countones({link, acc}) == $past($countones({link, acc})));

  // R4: a lone clear of the accumulator yields zero
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!load_en && instr_valid && is_grp1 && ctl.clr_a && !ctl.inv_a &&
     !ctl.inc && !ctl.rot_r && !ctl.rot_l && !ctl.dbl) |=> acc == '0);
endmodule

// File: tb/opr1_unit_bench.sv
module opr1_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid, load_en, load_link;
  logic [11:0] instr, load_acc;
  logic [11:0] acc;
  logic        link, rot_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  opr1_unit u_opr1_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .load_en(load_en), .load_acc(load_acc), .load_link(load_link),
    .acc(acc), .link(link), .rot_err(rot_err)
  );

  task automatic chk(input string tag, input logic [13:0] got, input logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // returns {err, link, acc}
  function automatic logic [13:0] model(input logic [11:0] w, input logic [11:0] a, input logic l);
    logic [11:0] x;
    logic        y;
    logic [12:0] v;
    if (w[11:9] != 3'd7 || w[8]) return {1'b0, l, a};
    if (w[3] && w[2]) return {1'b1, l, a};
    x = a; y = l;
    if (w[7]) x = 12'd0;
    if (w[6]) y = 1'b0;
    if (w[5]) x = 12'd4095 - x;
    if (w[4]) y = !y;
    if (w[0]) begin
      x = 12'((int'(x) + 1) % 4096);
      if (x == 12'd0) y = !y;
    end
    v = {y, x};
    if (w[3])      v = w[1] ? ((v >> 2) | (v << 11)) : ((v >> 1) | (v << 12));
    else if (w[2]) v = w[1] ? ((v << 2) | (v >> 11)) : ((v << 1) | (v >> 12));
    else if (w[1]) v = {v[12], 12'((int'(v[11:0]) % 64) * 64 + int'(v[11:0]) / 64)};
    return {1'b0, v};
  endfunction

  function automatic string tag_of(input logic [11:0] w);
    if (w[11:9] != 3'd7 || w[8]) return "R3";
    if (w[3] && w[2])            return "R10";
    if ((w[3] || w[2]) && w[1])  return "R8";
    if (w[3] || w[2])            return "R7";
    if (w[1])                    return "R9";
    if (w[0])                    return "R6";
    if (w[5] || w[4])            return "R5";
    return "R4";
  endfunction

  function automatic logic [11:0] acc_pat(input int i);
    case (i)
      0: return 12'o0000;   1: return 12'o7777;   2: return 12'o7776;
      3: return 12'o4000;   4: return 12'o0001;   5: return 12'o0077;
      6: return 12'o7700;   7: return 12'o5252;   8: return 12'o2525;
      9: return 12'o1234;  10: return 12'o6543;  11: return 12'o3777;
      12: return 12'o0100; 13: return 12'o7001;  14: return 12'o0707;
      default: return 12'o7070;
    endcase
  endfunction

  task automatic run_one(input logic [11:0] w, input logic [11:0] a, input logic l);
    logic [13:0] e;
    load_en = 1'b1; load_acc = a; load_link = l; instr_valid = 1'b0;
    @(negedge clk);
    load_en = 1'b0; instr_valid = 1'b1; instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
    e = model(w, a, l);
    chk(tag_of(w), {rot_err, link, acc}, e);
  endtask

  initial begin
    rst_n = 1'b0; instr_valid = 1'b0; load_en = 1'b0;
    instr = '0; load_acc = '0; load_link = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {rot_err, link, acc}, 14'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {rot_err, link, acc}, 14'd0);

    // R2: load, and load priority over a word
    load_en = 1'b1; load_acc = 12'o4321; load_link = 1'b1;
    @(negedge clk);
    chk("R2 load", {rot_err, link, acc}, {2'b01, 12'o4321});
    chk("R11 after load", {13'd0, rot_err}, 14'd0);
    load_acc = 12'o1111; load_link = 1'b0; instr_valid = 1'b1; instr = 12'o7200;
    @(negedge clk);
    load_en = 1'b0; instr_valid = 1'b0;
    chk("R2 priority", {rot_err, link, acc}, {2'b00, 12'o1111});

    // R3: no strobe
    instr = 12'o7200;
    @(negedge clk);
    chk("R3 no strobe", {rot_err, link, acc}, {2'b00, 12'o1111});

    // R4..R10: all group-1 words over a set of states
    for (int m = 0; m < 256; m++)
      for (int i = 0; i < 16; i++)
        for (int l = 0; l < 2; l++)
          run_one({4'b1110, 8'(m)}, acc_pat(i), 1'(l));

    // R3: foreign words
    for (int op = 0; op < 7; op++)
      for (int k = 0; k < 8; k++)
        run_one({3'(op), 9'((k * 37 + 5) % 512)}, 12'o5243, 1'b1);
    for (int m = 0; m < 256; m++)
      run_one({4'b1111, 8'(m)}, 12'o0316, 1'b0);

    // R11: flag drops after a conflict
    run_one(12'o7014, 12'o0005, 1'b0);
    @(negedge clk);
    chk("R11 flag clears", {13'd0, rot_err}, 14'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule